// File: doc/BRIEF.md
# Synthetic ADC Register Block

This block is a register-bus slave with the programming model of a small microcontroller analog-to-digital converter, but no converter behind it. Software can program control words, sample-time settings, watchdog thresholds, channel sequences and injected-channel offsets and data. All of these hold their values as if a real converter used them.

A read of the conversion-result register yields a synthetic result instead of a sample. An internal accumulator steps by a fixed increment, is cut to the programmed resolution, and is optionally left-aligned. The software-start request is consumed on the same edge. This lets driver code that polls and reads conversions run against a model with predictable numbers.

The bus is synchronous and single-cycle. Read data is registered. A one-cycle error flag marks accesses to offsets that hold no register. The interrupt output exists for pin compatibility and never asserts.

Top module: `synth_adc_regs`

## Requirements
- R1: After reset every register reads zero, except the high threshold (offset 0x24), which reads 0x00000FFF.
- R2: A read of the result register (offset 0x4C) returns zero and changes no state unless control word B (offset 0x08) has both bit 0 (converter on) and bit 30 (software start) set.
- R3: A qualifying result read clears the software-start bit, so a repeated read returns zero until it is set again. It advances the accumulator by 7 and masks it by control word A (offset 0x04) bits 25:24: 0 keeps 12 bits, 1 keeps 10, 2 keeps 8, 3 keeps 6.
- R4: When bit 11 of control word B is set, the qualifying read returns the masked accumulator shifted left by one and ANDed with 0xFFF0. Otherwise it returns the masked accumulator unchanged.
- R5: A write to the status register (offset 0x00) does not load the written value. The register becomes its old value ANDed with the low 6 written bits.
- R6: A read of control word B returns only bits 27:0 of the stored value. Bits 31:28 read as zero. Writes store all 32 bits.
- R7: The four injected offsets (offsets 0x14, 0x18, 0x1C, 0x20) keep only the low 12 bits of a write.
- R8: A read of injected data n (offsets 0x3C, 0x40, 0x44, 0x48) returns the stored data minus injected offset n, modulo 2^32.
- R9: Control word A, control word B, both sample-time words (0x0C, 0x10), both thresholds (0x24 high, 0x28 low), the three sequence words (0x2C, 0x30, 0x34) and the injected sequence (0x38) are plain 32-bit read/write storage.
- R10: Registers are word-aligned, and each sits at the offset given with it in these requirements.
- R11: An access to any other offset, including an offset that is not a multiple of 4 and any offset at or above 0x100, reads zero and changes no register. The error output pulses high for the one cycle in which that access's read data is due.
- R12: Read data appears on the first clock edge after the read enable and reads zero in cycles with no read. Back-to-back result reads see a new value only while software start stays set.
- R13: The interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq | output | 1 | Interrupt, held low |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it. Read data, the error flag and the software-start side effect all update on the edge that samples the read enable, and writes become visible to a read issued in the next cycle. The bench drives each access at a falling edge and samples read data and error on the following falling edge, half a cycle after they settle. The back-to-back result test holds the read enable over two edges and samples once after each. A bench-side accumulator model supplies every expected conversion value across all resolution and alignment settings, including a full 12-bit wrap.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

   localparam int IDX_W     = 2;
   localparam int STAT_W    = 6;
   localparam int BIT_ON    = 0;
   localparam int BIT_ALIGN = 11;
   localparam int BIT_SWGO  = 30;
   localparam int RES_LO    = 24;
   localparam int CTLB_VIS  = 28;
   localparam int OFS_KEEP  = 12;

   typedef enum logic [3:0] {
      K_NONE, K_STAT, K_CTLA, K_CTLB, K_SMPA, K_SMPB, K_OFS,
      K_THRH, K_THRL, K_SEQ, K_ISEQ, K_IDAT, K_CONV
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e        kind;
      logic [IDX_W-1:0] idx;
   } reg_sel_t;

   function automatic logic [11:0] res_mask(input logic [1:0] res);
      case (res)
         2'd0:    return 12'hFFF;
         2'd1:    return 12'h3FF;
         2'd2:    return 12'h0FF;
         default: return 12'h03F;
      endcase
   endfunction

endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
   import adc_regs_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int N_INJ  = 4,
   parameter int N_SEQ  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   localparam int W_OFS  = 5;
   localparam int W_THRH = W_OFS + N_INJ;
   localparam int W_THRL = W_THRH + 1;
   localparam int W_SEQ  = W_THRL + 1;
   localparam int W_ISEQ = W_SEQ + N_SEQ;
   localparam int W_IDAT = W_ISEQ + 1;
   localparam int W_CONV = W_IDAT + N_INJ;

   int unsigned w;

   always_comb begin
      sel.kind = K_NONE;
      sel.idx  = '0;
      w        = 32'(addr[ADDR_W-1:2]);
      if (addr[1:0] == 2'b00) begin
         if      (w == 0) sel.kind = K_STAT;
         else if (w == 1) sel.kind = K_CTLA;
         else if (w == 2) sel.kind = K_CTLB;
         else if (w == 3) sel.kind = K_SMPA;
         else if (w == 4) sel.kind = K_SMPB;
         else if (w >= W_OFS && w < W_THRH) begin
            sel.kind = K_OFS;
            sel.idx  = IDX_W'(w - W_OFS);
         end
         else if (w == W_THRH) sel.kind = K_THRH;
         else if (w == W_THRL) sel.kind = K_THRL;
         else if (w >= W_SEQ && w < W_ISEQ) begin
            sel.kind = K_SEQ;
            sel.idx  = IDX_W'(w - W_SEQ);
         end
         else if (w == W_ISEQ) sel.kind = K_ISEQ;
         else if (w >= W_IDAT && w < W_CONV) begin
            sel.kind = K_IDAT;
            sel.idx  = IDX_W'(w - W_IDAT);
         end
         else if (w == W_CONV) sel.kind = K_CONV;
      end
   end

endmodule

// File: rtl/adc_fake_conv.sv
module adc_fake_conv
   import adc_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STEP   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [1:0]        res,
   input  logic              align,
   output logic [DATA_W-1:0] result
);
   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] nxt;

   generate
      if (STEP < 1 || STEP > 63) begin : g_bad_step
         $error("adc_fake_conv: STEP out of range");
      end
   endgenerate

   always_comb begin
      nxt    = (acc + STEP_V) & DATA_W'(res_mask(res));
      result = align ? ((nxt << 1) & DATA_W'(16'hFFF0)) : nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (step) acc <= nxt;
   end

   // R2
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(acc));

endmodule

// File: rtl/adc_inj_bank.sv
module adc_inj_bank
   import adc_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N_INJ  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ofs_wr,
   input  logic              dat_wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ofs_rd,
   output logic [DATA_W-1:0] dat_rd
);
   logic [OFS_KEEP-1:0] ofs_q [N_INJ];
   logic [DATA_W-1:0]   dat_q [N_INJ];

   generate
      for (genvar i = 0; i < N_INJ; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ofs_q[i] <= '0;
               dat_q[i] <= '0;
            end else begin
               if (ofs_wr && idx == IDX_W'(i)) ofs_q[i] <= wdata[OFS_KEEP-1:0];
               if (dat_wr && idx == IDX_W'(i)) dat_q[i] <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      ofs_rd = '0;
      dat_rd = '0;
      for (int i = 0; i < N_INJ; i++) begin
         if (idx == IDX_W'(i)) begin
            ofs_rd = DATA_W'(ofs_q[i]);
            dat_rd = dat_q[i] - DATA_W'(ofs_q[i]);
         end
      end
   end

endmodule

// File: rtl/synth_adc_regs.sv
module synth_adc_regs
   import adc_regs_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int N_INJ  = 4,
   parameter int N_SEQ  = 3,
   parameter int STEP   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              irq
);
   localparam logic [DATA_W-1:0] THRH_RST = DATA_W'(12'hFFF);
   localparam logic [DATA_W-1:0] CTLB_MSK = DATA_W'((64'd1 << CTLB_VIS) - 1);

   generate
      if (DATA_W != 32)            begin : g_bad_dw   $error("DATA_W must be 32"); end
      if (ADDR_W < 9)              begin : g_bad_aw   $error("ADDR_W too small"); end
      if (N_INJ < 1 || N_INJ > 4)  begin : g_bad_inj  $error("N_INJ out of range"); end
      if (N_SEQ < 1 || N_SEQ > 4)  begin : g_bad_seq  $error("N_SEQ out of range"); end
   endgenerate

   reg_sel_t sel;
   adc_addr_decode #(.ADDR_W(ADDR_W), .N_INJ(N_INJ), .N_SEQ(N_SEQ)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   logic [STAT_W-1:0] stat;
   logic [DATA_W-1:0] ctla, ctlb, smpa, smpb, thrh, thrl, iseq;
   logic [DATA_W-1:0] seq [N_SEQ];

   logic qual;
   assign qual = bus_re && sel.kind == K_CONV && ctlb[BIT_ON] && ctlb[BIT_SWGO];

   logic [DATA_W-1:0] conv_val, ofs_rd, idat_rd;

   adc_fake_conv #(.DATA_W(DATA_W), .STEP(STEP)) u_conv (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (qual),
      .res    (ctla[RES_LO+1:RES_LO]),
      .align  (ctlb[BIT_ALIGN]),
      .result (conv_val)
   );

   adc_inj_bank #(.DATA_W(DATA_W), .N_INJ(N_INJ)) u_inj (
      .clk    (clk),
      .rst_n  (rst_n),
      .ofs_wr (bus_we && sel.kind == K_OFS),
      .dat_wr (bus_we && sel.kind == K_IDAT),
      .idx    (sel.idx),
      .wdata  (bus_wdata),
      .ofs_rd (ofs_rd),
      .dat_rd (idat_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         ctla <= '0;
         ctlb <= '0;
         smpa <= '0;
         smpb <= '0;
         thrh <= THRH_RST;
         thrl <= '0;
         iseq <= '0;
      end else begin
         if (bus_we) begin
            case (sel.kind)
               K_STAT:  stat <= stat & bus_wdata[STAT_W-1:0];
               K_CTLA:  ctla <= bus_wdata;
               K_SMPA:  smpa <= bus_wdata;
               K_SMPB:  smpb <= bus_wdata;
               K_THRH:  thrh <= bus_wdata;
               K_THRL:  thrl <= bus_wdata;
               K_ISEQ:  iseq <= bus_wdata;
               default: ;
            endcase
         end
         if (bus_we && sel.kind == K_CTLB) ctlb <= bus_wdata;
         else if (qual)                    ctlb[BIT_SWGO] <= 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < N_SEQ; i++) begin : g_seq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seq[i] <= '0;
            else if (bus_we && sel.kind == K_SEQ && sel.idx == IDX_W'(i))
               seq[i] <= bus_wdata;
         end
      end
   endgenerate

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (sel.kind)
         K_STAT:  rd_mux = DATA_W'(stat);
         K_CTLA:  rd_mux = ctla;
         K_CTLB:  rd_mux = ctlb & CTLB_MSK;
         K_SMPA:  rd_mux = smpa;
         K_SMPB:  rd_mux = smpb;
         K_OFS:   rd_mux = ofs_rd;
         K_THRH:  rd_mux = thrh;
         K_THRL:  rd_mux = thrl;
         K_ISEQ:  rd_mux = iseq;
         K_IDAT:  rd_mux = idat_rd;
         K_CONV:  rd_mux = qual ? conv_val : '0;
         K_SEQ: begin
            for (int i = 0; i < N_SEQ; i++)
               if (sel.idx == IDX_W'(i)) rd_mux = seq[i];
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= bus_re ? rd_mux : '0;
         bus_err   <= (bus_re || bus_we) && sel.kind == K_NONE;
      end
   end

   assign irq = 1'b0;

   // R2
   conv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re && sel.kind == K_CONV && !(ctlb[BIT_ON] && ctlb[BIT_SWGO]) |=> bus_rdata == '0);

   // R3
   swgo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual && !(bus_we && sel.kind == K_CTLB) |=> !ctlb[BIT_SWGO]);

   // R4
   align_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qual && ctlb[BIT_ALIGN] |=> bus_rdata[3:0] == 4'h0 && bus_rdata[DATA_W-1:16] == '0);

   // R5
   stat_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && sel.kind == K_STAT |=> (stat & ~$past(stat)) == '0);

   // R6
   ctlb_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re && sel.kind == K_CTLB |=> bus_rdata[DATA_W-1:CTLB_VIS] == '0);

   // R7
   ofs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re && sel.kind == K_OFS |=> bus_rdata[DATA_W-1:OFS_KEEP] == '0);

   // R11
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_rdata == '0);

   // R12
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> bus_rdata == '0);

endmodule

// File: tb/synth_adc_regs_tb.sv
module synth_adc_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   synth_adc_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      e = bus_err;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   logic [31:0] mdr = '0;

   function automatic logic [31:0] msk(input int res);
      case (res)
         0: return 32'hFFF;
         1: return 32'h3FF;
         2: return 32'hFF;
         default: return 32'h3F;
      endcase
   endfunction

   // arm, read, compare against bench accumulator model (R3, R4)
   task automatic conv_once(input int res, input int aln);
      logic [31:0] d, exp;
      logic e;
      wr(12'h008, 32'h4000_0001 | (32'(aln) << 11), e);
      rd(12'h04C, d, e);
      mdr = (mdr + 32'd7) & msk(res);
      exp = aln != 0 ? ((mdr << 1) & 32'hFFF0) : mdr;
      chk(aln != 0 ? "R4 aligned result" : "R3 stepped result", d, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d, d2;
      logic e;
      logic [11:0] plain [11];
      logic [31:0] pats [4];
      plain = '{12'h004, 12'h00C, 12'h010, 12'h024, 12'h028, 12'h02C,
                12'h030, 12'h034, 12'h038, 12'h008, 12'h000};
      pats  = '{32'hA5A5_5A5A, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values across the map (R10 offsets)
      for (int a = 0; a <= 'h4C; a += 4) begin
         rd(12'(a), d, e);
         chk("R1 reset value", d, a == 'h24 ? 32'hFFF : 32'h0);
         chk("R10 mapped no err", 32'(e), 0);
      end
      chk("R13 irq low", 32'(irq), 0);
      chk("R12 idle rdata zero", bus_rdata, 0);

      // R9 plain storage
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < 9; i++) wr(plain[i], pats[p] ^ 32'(i), e);
         for (int i = 0; i < 9; i++) begin
            rd(plain[i], d, e);
            chk("R9 plain register", d, pats[p] ^ 32'(i));
         end
      end
      wr(12'h004, 32'h0, e);

      // R6 control word B top bits hidden
      wr(12'h008, 32'hF000_0800, e);
      rd(12'h008, d, e);
      chk("R6 ctl B masked read", d, 32'h0000_0800);
      wr(12'h008, 32'hAFFF_FFFE, e);
      rd(12'h008, d, e);
      chk("R6 ctl B masked read", d, 32'h0FFF_FFFE);

      // R5 status write ANDs
      wr(12'h000, 32'hFFFF_FFFF, e);
      rd(12'h000, d, e);
      chk("R5 status no load", d, 0);

      // R7 offsets, R8 injected difference
      for (int n = 0; n < 4; n++) begin
         wr(12'(12'h014 + 4*n), 32'hABCD_E000 | 32'(n*12'h111 + 1), e);
         rd(12'(12'h014 + 4*n), d, e);
         chk("R7 offset 12 bits", d, 32'(n*12'h111 + 1));
      end
      for (int n = 0; n < 4; n++) begin
         wr(12'(12'h03C + 4*n), 32'(n * 1000), e);
         rd(12'(12'h03C + 4*n), d, e);
         chk("R8 injected data minus offset", d, 32'(n * 1000) - 32'(n*12'h111 + 1));
      end

      // R2 gating: on-only, start-only, both clear
      wr(12'h008, 32'h0000_0001, e);
      rd(12'h04C, d, e);
      chk("R2 on only reads zero", d, 0);
      wr(12'h008, 32'h4000_0000, e);
      rd(12'h04C, d, e);
      chk("R2 start only reads zero", d, 0);
      wr(12'h008, 32'h0, e);
      rd(12'h04C, d, e);
      chk("R2 idle reads zero", d, 0);

      // R3/R4 sweep over resolutions and alignment
      for (int aln = 0; aln < 2; aln++)
         for (int res = 0; res < 4; res++) begin
            wr(12'h004, 32'(res) << 24, e);
            for (int k = 0; k < 6; k++) conv_once(res, aln);
         end

      // R3 start consumed: repeat read returns zero, counter untouched
      wr(12'h004, 32'h0, e);
      wr(12'h008, 32'h4000_0001, e);
      rd(12'h04C, d, e);
      mdr = (mdr + 7) & 32'hFFF;
      chk("R3 first read", d, mdr);
      rd(12'h04C, d, e);
      chk("R3 start consumed", d, 0);

      // R12 back-to-back reads
      wr(12'h008, 32'h4000_0001, e);
      @(negedge clk);
      bus_addr = 12'h04C; bus_re = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      @(negedge clk);
      bus_re = 1'b0;
      d2 = bus_rdata;
      mdr = (mdr + 7) & 32'hFFF;
      chk("R12 back-to-back first", d, mdr);
      chk("R12 back-to-back second", d2, 0);
      @(negedge clk);
      chk("R12 zero after read", bus_rdata, 0);

      // R3 12-bit wrap
      for (int k = 0; k < 600; k++) conv_once(0, 0);

      // R11 unmapped offsets
      for (int a = 'h50; a < 'h200; a += 4) begin
         wr(12'(a), 32'hFFFF_FFFF, e);
         chk("R11 write err", 32'(e), 1);
         rd(12'(a), d, e);
         chk("R11 read zero", d, 0);
         chk("R11 read err", 32'(e), 1);
      end
      wr(12'h025, 32'h1, e);
      chk("R11 misaligned err", 32'(e), 1);
      rd(12'h024, d, e);
      chk("R11 writes ignored", d, pats[3] ^ 32'd3);
      rd(12'h02C, d, e);
      chk("R11 writes ignored", d, pats[3] ^ 32'd5);
      @(negedge clk);
      chk("R11 err one cycle", 32'(bus_err), 0);
      chk("R13 irq low", 32'(irq), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule